// File: doc/BRIEF.md
# Segmented Virtual Address Translator

This block turns a 32-bit virtual address into a physical address, or reports that it cannot. The upper four address bits pick one of sixteen 256 MB segments. Each segment is configured either for linear remapping or for paged translation. In linear mode the segment's 4-bit physical base replaces the top nibble and the low 28 bits pass through unchanged. In paged mode the block only flags that a downstream page lookup must resolve the address.

Software programs one segment-mode word and two base words through a small register-write port. The requester presents an address with a user/kernel flag. One cycle later the block returns exactly one of three outcomes: a valid physical address, a page-lookup request, or a fault.

A user-mode access above the user window faults. An access to the lowest 8 KB page faults in either mode.

Top module: `seg_xlate_top`

## Requirements
- R1: After reset, `pa_valid`, `walk_req` and `fault` are low and `pa` is zero. Every segment starts linear with a base equal to its own index, so a kernel request comes back with `pa` equal to the address.
- R2: A request to a linear segment that does not fault sets `pa_valid` on the clock edge that accepts it. `pa` is the segment's 4-bit base followed by address bits 27:0.
- R3: A request to a paged segment that does not fault sets `walk_req`, leaves `pa_valid` low, and returns the unchanged address on `pa`.
- R4: A user-mode request (`req_user`=1) whose bits 31:28 exceed 0xA faults. 0xAFFFFFFF is still allowed, and kernel mode has no such limit.
- R5: Any request with bits 31:13 all zero (addresses 0x0000 to 0x1FFF) faults in both modes. Address 0x2000 does not fault.
- R6: A write with `cfg_sel`=0 loads the mode word. Bit i set to 1 makes segment i paged, and bit i cleared to 0 makes it linear.
- R7: A write with `cfg_sel`=1 loads the bases of segments 0 to 7, and a write with `cfg_sel`=2 loads the bases of segments 8 to 15. In both cases the base of segment k sits in data bits 4(k mod 8)+3 down to 4(k mod 8).
- R8: A request made in the same cycle as a configuration write is translated with the old configuration. The write applies to the next request.
- R9: A cycle with no request clears all three flags and `pa` one cycle later.
- R10: Each accepted request raises exactly one of `pa_valid`, `walk_req`, `fault`. On a fault, `pa` is zero.
- R11: A write with `cfg_sel`=3 changes no mode or base.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Configuration target: 0 mode word, 1 low bases, 2 high bases, 3 none |
| cfg_wdata | input | 32 | Configuration write data |
| req_valid | input | 1 | Translation request present |
| req_addr | input | 32 | Virtual address |
| req_user | input | 1 | 1 = user mode, 0 = kernel mode |
| pa_valid | output | 1 | Physical address valid |
| pa | output | 32 | Physical address, or the unchanged virtual address for a page lookup |
| walk_req | output | 1 | Page lookup needed |
| fault | output | 1 | Access fault |

## Verification
The bench builds the block with its default parameters: 32-bit addresses, 4 segment bits, 13 page bits and 0xA as the highest user segment. With these values all sixteen segments and both base words can be reached, along with the exact edges 0x1FFF/0x2000 and 0xAFFFFFFF/0xB0000000. A behavioural model with per-segment arrays predicts every output on every clock. The test covers a write and a request landing in the same cycle, and a write to the unused select code.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;

  typedef enum logic [1:0] {
    SEL_MODE    = 2'd0,
    SEL_BASE_LO = 2'd1,
    SEL_BASE_HI = 2'd2,
    SEL_RSVD    = 2'd3
  } cfg_sel_e;

  typedef struct packed {
    logic fault;
    logic walk;
    logic hit;
  } xlate_flags_t;

endpackage

// File: rtl/seg_rst_sync.sv
module seg_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_async,
  output logic rst_n_sync
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_async) begin
    if (!rst_n_async) sync_q <= '0;
    else              sync_q <= sync_d;
  end

  assign rst_n_sync = sync_q[STAGES-1];

endmodule

// File: rtl/seg_cfg_regs.sv
module seg_cfg_regs
  import seg_xlate_pkg::*;
#(
  parameter int NSEG   = 16,
  parameter int BASE_W = 4,
  parameter int DATA_W = 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   we,
  input  logic [1:0]             sel,
  input  logic [DATA_W-1:0]      wdata,
  output logic [NSEG-1:0]        seg_paged,
  output logic [NSEG*BASE_W-1:0] seg_base
);

  localparam int HALF = NSEG / 2;

  cfg_sel_e        sel_e;
  logic            mode_en;
  logic            lo_en;
  logic            hi_en;
  logic [NSEG-1:0] mode_q;
  logic [NSEG-1:0] mode_d;

  assign sel_e = cfg_sel_e'(sel);

  always_comb begin
    mode_en = 1'b0;
    lo_en   = 1'b0;
    hi_en   = 1'b0;
    if (we) begin
      case (sel_e)
        SEL_MODE:    mode_en = 1'b1;
        SEL_BASE_LO: lo_en   = 1'b1;
        SEL_BASE_HI: hi_en   = 1'b1;
        default:     ;
      endcase
    end
    mode_d = wdata[NSEG-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mode_q <= '0;
    else if (mode_en) mode_q <= mode_d;
  end

  assign seg_paged = mode_q;

  for (genvar g = 0; g < NSEG; g++) begin : g_base
    localparam int SLOT = g % HALF;
    logic              en;
    logic [BASE_W-1:0] base_q;
    logic [BASE_W-1:0] base_d;

    if (g < HALF) begin : g_lo
      assign en = lo_en;
    end else begin : g_hi
      assign en = hi_en;
    end

    always_comb begin
      base_d = wdata[SLOT*BASE_W +: BASE_W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  base_q <= BASE_W'(g);
      else if (en) base_q <= base_d;
    end

    assign seg_base[g*BASE_W +: BASE_W] = base_q;
  end

endmodule

// File: rtl/seg_lookup.sv
module seg_lookup
  import seg_xlate_pkg::*;
#(
  parameter int VA_W         = 32,
  parameter int SEG_BITS     = 4,
  parameter int PAGE_BITS    = 13,
  parameter int USER_TOP_SEG = 10
) (
  input  logic [VA_W-1:0]                   va,
  input  logic                              user,
  input  logic [(1<<SEG_BITS)-1:0]          seg_paged,
  input  logic [(1<<SEG_BITS)*SEG_BITS-1:0] seg_base,
  output xlate_flags_t                      flags,
  output logic [VA_W-1:0]                   pa
);

  localparam int OFF_W = VA_W - SEG_BITS;
  localparam logic [SEG_BITS-1:0] USER_TOP = SEG_BITS'(USER_TOP_SEG);

  logic [SEG_BITS-1:0] seg;
  logic [OFF_W-1:0]    offset;
  logic [SEG_BITS-1:0] base;
  logic                first_page;
  logic                user_out;
  logic                is_paged;

  always_comb begin
    seg        = va[VA_W-1 -: SEG_BITS];
    offset     = va[OFF_W-1:0];
    base       = seg_base[seg*SEG_BITS +: SEG_BITS];
    is_paged   = seg_paged[seg];
    first_page = (va[VA_W-1:PAGE_BITS] == '0);
    user_out   = user && (seg > USER_TOP);

    flags = '0;
    pa    = '0;
    if (first_page || user_out) begin
      flags.fault = 1'b1;
    end else if (is_paged) begin
      flags.walk = 1'b1;
      pa         = va;
    end else begin
      flags.hit = 1'b1;
      pa        = {base, offset};
    end
  end

endmodule

// File: rtl/seg_result_reg.sv
module seg_result_reg
  import seg_xlate_pkg::*;
#(
  parameter int PA_W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  xlate_flags_t flags_in,
  input  logic [PA_W-1:0] pa_in,
  output xlate_flags_t flags_q,
  output logic [PA_W-1:0] pa_q
);

  xlate_flags_t    flags_d;
  logic [PA_W-1:0] pa_d;

  always_comb begin
    flags_d = '0;
    pa_d    = '0;
    if (load) begin
      flags_d = flags_in;
      pa_d    = pa_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
      pa_q    <= '0;
    end else begin
      flags_q <= flags_d;
      pa_q    <= pa_d;
    end
  end

endmodule

// File: rtl/seg_xlate_top.sv
module seg_xlate_top
  import seg_xlate_pkg::*;
#(
  parameter int VA_W         = 32,
  parameter int SEG_BITS     = 4,
  parameter int PAGE_BITS    = 13,
  parameter int USER_TOP_SEG = 10,
  parameter int CFG_W        = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_sel,
  input  logic [CFG_W-1:0] cfg_wdata,
  input  logic             req_valid,
  input  logic [VA_W-1:0]  req_addr,
  input  logic             req_user,
  output logic             pa_valid,
  output logic [VA_W-1:0]  pa,
  output logic             walk_req,
  output logic             fault
);

  localparam int NSEG = 1 << SEG_BITS;

  logic                   rst_n_sync;
  logic [NSEG-1:0]        seg_paged;
  logic [NSEG*SEG_BITS-1:0] seg_base;
  xlate_flags_t           look_flags;
  logic [VA_W-1:0]        look_pa;
  xlate_flags_t           res_flags;

  seg_rst_sync #(.STAGES(2)) u_rst (
    .clk         (clk),
    .rst_n_async (rst_n),
    .rst_n_sync  (rst_n_sync)
  );

  seg_cfg_regs #(.NSEG(NSEG), .BASE_W(SEG_BITS), .DATA_W(CFG_W)) u_cfg (
    .clk       (clk),
    .rst_n     (rst_n_sync),
    .we        (cfg_we),
    .sel       (cfg_sel),
    .wdata     (cfg_wdata),
    .seg_paged (seg_paged),
    .seg_base  (seg_base)
  );

  seg_lookup #(
    .VA_W(VA_W), .SEG_BITS(SEG_BITS), .PAGE_BITS(PAGE_BITS), .USER_TOP_SEG(USER_TOP_SEG)
  ) u_look (
    .va        (req_addr),
    .user      (req_user),
    .seg_paged (seg_paged),
    .seg_base  (seg_base),
    .flags     (look_flags),
    .pa        (look_pa)
  );

  seg_result_reg #(.PA_W(VA_W)) u_res (
    .clk      (clk),
    .rst_n    (rst_n_sync),
    .load     (req_valid),
    .flags_in (look_flags),
    .pa_in    (look_pa),
    .flags_q  (res_flags),
    .pa_q     (pa)
  );

  assign pa_valid = res_flags.hit;
  assign walk_req = res_flags.walk;
  assign fault    = res_flags.fault;

endmodule

// File: rtl/seg_xlate_checker.sv
module seg_xlate_checker #(
  parameter int VA_W         = 32,
  parameter int SEG_BITS     = 4,
  parameter int PAGE_BITS    = 13,
  parameter int USER_TOP_SEG = 10
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic [VA_W-1:0] req_addr,
  input logic            req_user,
  input logic            pa_valid,
  input logic [VA_W-1:0] pa,
  input logic            walk_req,
  input logic            fault
);

  localparam int OFF_W = VA_W - SEG_BITS;
  localparam logic [SEG_BITS-1:0] USER_TOP = SEG_BITS'(USER_TOP_SEG);

  a_r10_single_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({pa_valid, walk_req, fault}));

  a_r10_request_answered: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (pa_valid || walk_req || fault));

  a_r9_idle_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!pa_valid && !walk_req && !fault && pa == '0));

  a_r4_user_window: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_user && (req_addr[VA_W-1 -: SEG_BITS] > USER_TOP)) |=> fault);

  a_r5_null_page: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && (req_addr[VA_W-1:PAGE_BITS] == '0)) |=> fault);

  a_r2_offset_kept: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (!pa_valid || pa[OFF_W-1:0] == $past(req_addr[OFF_W-1:0])));

  a_r3_walk_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (!walk_req || pa == $past(req_addr)));

endmodule

bind seg_xlate_top seg_xlate_checker #(
  .VA_W(VA_W), .SEG_BITS(SEG_BITS), .PAGE_BITS(PAGE_BITS), .USER_TOP_SEG(USER_TOP_SEG)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n_sync),
  .req_valid (req_valid),
  .req_addr  (req_addr),
  .req_user  (req_user),
  .pa_valid  (pa_valid),
  .pa        (pa),
  .walk_req  (walk_req),
  .fault     (fault)
);

// File: tb/test_seg_xlate_top.sv
module test_seg_xlate_top;

  logic        clk;
  logic        rst_n;
  logic        cfg_we;
  logic [1:0]  cfg_sel;
  logic [31:0] cfg_wdata;
  logic        req_valid;
  logic [31:0] req_addr;
  logic        req_user;
  logic        pa_valid;
  logic [31:0] pa;
  logic        walk_req;
  logic        fault;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  bit mode_m [16];
  int base_m [16];

  bit          e_pv, e_wr, e_ft;
  logic [31:0] e_pa;

  seg_xlate_top i_seg_xlate_top (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .req_valid(req_valid), .req_addr(req_addr), .req_user(req_user),
    .pa_valid(pa_valid), .pa(pa), .walk_req(walk_req), .fault(fault)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic predict(input bit rv, input logic [31:0] a, input bit u);
    int seg;
    seg = int'(a >> 28);
    e_pv = 0; e_wr = 0; e_ft = 0; e_pa = 32'h0;
    if (rv) begin
      if (a < 32'h2000 || (u && seg > 10)) e_ft = 1;
      else if (mode_m[seg]) begin e_wr = 1; e_pa = a; end
      else begin e_pv = 1; e_pa = (32'(base_m[seg]) << 28) | (a & 32'h0FFF_FFFF); end
    end
  endtask

  task automatic model_write(input bit we, input logic [1:0] sel, input logic [31:0] wd);
    if (!we) return;
    for (int k = 0; k < 16; k++) begin
      if (sel == 2'd0) mode_m[k] = wd[k];
      if (sel == 2'd1 && k < 8)  base_m[k] = int'((wd >> (4*k)) & 32'hF);
      if (sel == 2'd2 && k >= 8) base_m[k] = int'((wd >> (4*(k-8))) & 32'hF);
    end
  endtask

  task automatic compare(input string tag);
    checks++;
    if (pa_valid !== e_pv || walk_req !== e_wr || fault !== e_ft || pa !== e_pa) begin
      errors++;
      $display("FAIL %s: pv=%0b wr=%0b ft=%0b pa=%h expected pv=%0b wr=%0b ft=%0b pa=%h",
               tag, pa_valid, walk_req, fault, pa, e_pv, e_wr, e_ft, e_pa);
    end
  endtask

  // starts and ends at a falling edge
  task automatic cyc(input bit we, input logic [1:0] sel, input logic [31:0] wd,
                     input bit rv, input logic [31:0] a, input bit u, input string tag);
    cfg_we = we; cfg_sel = sel; cfg_wdata = wd;
    req_valid = rv; req_addr = a; req_user = u;
    @(posedge clk);
    predict(rv, a, u);
    model_write(we, sel, wd);
    @(negedge clk);
    compare(tag);
    if (rv) begin
      checks++;
      if ($countones({pa_valid, walk_req, fault}) != 1) begin
        errors++;
        $display("FAIL R10: flags=%b expected one set", {pa_valid, walk_req, fault});
      end
    end
  endtask

  task automatic req(input logic [31:0] a, input bit u, input string tag);
    cyc(0, 2'd0, 32'h0, 1, a, u, tag);
  endtask

  task automatic wr(input logic [1:0] sel, input logic [31:0] wd, input string tag);
    cyc(1, sel, wd, 0, 32'h0, 0, tag);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not end");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < 16; k++) begin mode_m[k] = 0; base_m[k] = k; end
    rst_n = 0; cfg_we = 0; cfg_sel = 0; cfg_wdata = 0;
    req_valid = 0; req_addr = 0; req_user = 0;
    repeat (3) @(negedge clk);
    // R1: outputs low while in reset
    e_pv = 0; e_wr = 0; e_ft = 0; e_pa = 0;
    compare("R1 reset");
    rst_n = 1;
    repeat (3) cyc(0, 2'd0, 32'h0, 0, 32'h0, 0, "R9 idle after reset");

    req(32'hC000_1234, 0, "R1 identity map");
    req(32'h3ABC_DEF0, 0, "R1 identity map low half");

    wr(2'd0, 32'h0000_2000, "R6 mode word seg D paged");
    cyc(1, 2'd2, 32'h08D4_BA98, 1, 32'hC000_1000, 0, "R8 same-cycle write uses old base");
    req(32'hC000_1000, 0, "R2 seg C base 4");
    req(32'hB000_0010, 0, "R2 seg B base B");
    req(32'hE123_4567, 0, "R7 seg E base 8");
    req(32'hF000_0004, 0, "R7 seg F base 0");
    req(32'hD004_000C, 0, "R3 paged seg D");
    req(32'hD004_000C, 1, "R4 user above window");
    req(32'hAFFF_FFFF, 1, "R4 user top of window");
    req(32'hB000_0000, 1, "R4 user first excluded");
    req(32'hF000_0000, 0, "R4 kernel unlimited");
    req(32'h0000_1FFF, 0, "R5 null page kernel");
    req(32'h0000_0000, 1, "R5 null page user");
    req(32'h0000_2000, 0, "R5 first mapped page");

    wr(2'd1, 32'h7654_3250, "R7 low bases");
    req(32'h1000_2000, 1, "R7 seg 1 base 5");
    req(32'h0000_4000, 0, "R7 seg 0 base 0");

    wr(2'd3, 32'hFFFF_FFFF, "R11 reserved select");
    req(32'hC000_0040, 0, "R11 bases unchanged");
    req(32'hD000_2000, 0, "R11 modes unchanged");

    wr(2'd0, 32'h0000_0003, "R6 segs 0 and 1 paged");
    req(32'h1000_0000, 0, "R6 seg 1 now paged");
    req(32'h0000_1000, 0, "R5 null page beats paging");
    req(32'hD000_2000, 0, "R6 seg D back to linear");
    cyc(0, 2'd0, 32'h0, 0, 32'hC000_0000, 0, "R9 no request clears");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule